// File: doc/BRIEF.md
# Real-Time Clock Register Block with Interrupt Groups

This block is the software-visible face of a real-time clock. A host reaches it over a plain 32-bit register bus with one word per access. The block keeps the values the host programs: the time to load, the calibration word, the alarm time, the control word and a scratch safety word. It also returns the live values that the counting logic supplies on input ports: the running seconds count, the sub-second tick, a snapshot of the loaded time and the calibration word in use. The counting and calibration arithmetic sit outside this block.

There are two interrupt groups, and each drives its own level output. The first group has two sources, an alarm match and a seconds strobe. The second group has one source, which flags a write that the block cannot accept. Each group has sticky status bits that the host clears by writing ones. Its mask cannot be written directly. The host clears mask bits through an enable register and sets them through a disable register. An output is high while any status bit is set whose mask bit is clear.

A write to a read-only or unmapped word sets the address-error flag. While the error-response enable in the control word is set, the same write also raises a one-cycle error response on the bus.

Top module: `rtc_csr`

## Requirements
- R1: After reset the main mask reads 0x3, the address-error mask reads 0x1, control reads 0x01000000, both status words read 0, and both interrupt outputs and bus_err are low.
- R2: The main status word at byte offset 0x20 has the alarm flag in bit 1 and the seconds flag in bit 0. Each bit is set by a pulse on its event input and cleared by writing a one to it. Writing a zero leaves the bit unchanged.
- R3: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R4: Writes to the mask words (0x24 main, 0x34 address-error) leave them unchanged. Writing ones to 0x28/0x38 clears those mask bits, and writing ones to 0x2C/0x3C sets them. The enable and disable words read 0.
- R5: irq_rtc reflects (status & ~mask) != 0 from the same clock edge at which status or mask changes.
- R6: The address-error group is bit 0 at offsets 0x30 (status, write-one-to-clear), 0x34 (mask), 0x38 (enable) and 0x3C (disable), and it drives irq_aerr under the rule of R5.
- R7: A write to a read-only offset (0x04, 0x0C, 0x10, 0x14, 0x24, 0x34) or to an unmapped offset sets the address-error status bit.
- R8: bus_err is high for exactly the cycle after a rejected write, and only when control bit 0 was set. An accepted write never raises it.
- R9: The calibration word at 0x08 keeps bits 20:0 (max tick 15:0, fraction 19:16, fraction enable 20) and drives calib_o. The word at 0x0C returns calib_live_i.
- R10: Control at 0x40 keeps bits 31, 27:24 and 0. All other bits read 0.
- R11: Offset 0x10 returns time_now_i, 0x14 returns tick_now_i zero-extended, and 0x04 returns time_snap_i.
- R12: Read data appears on bus_rdata one cycle after the read request. A read of an unmapped offset returns 0 and does not set the address-error flag.
- R13: Set-time at 0x00, alarm at 0x18 and safety at 0x50 hold a full 32-bit written value. Set-time drives set_time_o and alarm drives alarm_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Error response for a rejected write |
| time_now_i | input | 32 | Running seconds count |
| tick_now_i | input | 16 | Sub-second tick count |
| time_snap_i | input | 32 | Loaded-time snapshot |
| calib_live_i | input | 21 | Calibration value in use |
| ev_sec | input | 1 | Seconds event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| set_time_o | output | 32 | Programmed set-time value |
| calib_o | output | 21 | Programmed calibration value |
| alarm_o | output | 32 | Programmed alarm value |
| ctrl_o | output | 32 | Control word |
| irq_rtc | output | 1 | Alarm/seconds interrupt level |
| irq_aerr | output | 1 | Address-error interrupt level |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that bus_en, bus_wr, bus_addr, bus_wdata and the event pulses are stable around each rising edge, and that only one access is presented per cycle. The bench changes every input at the falling edge and runs one access per task call. It keeps the event pulses one cycle wide, so each edge sees one well-defined combination of write and event, including the deliberate case of a clear and an event in the same cycle.

// File: rtl/rtc_csr_pkg.sv
package rtc_csr_pkg;

  // word indices of the register map (byte offset / 4)
  typedef enum logic [4:0] {
    REG_TSET  = 5'd0,
    REG_TSNAP = 5'd1,
    REG_CALW  = 5'd2,
    REG_CALR  = 5'd3,
    REG_TNOW  = 5'd4,
    REG_TICK  = 5'd5,
    REG_ALRM  = 5'd6,
    REG_ISTAT = 5'd8,
    REG_IMASK = 5'd9,
    REG_IEN   = 5'd10,
    REG_IDIS  = 5'd11,
    REG_ESTAT = 5'd12,
    REG_EMASK = 5'd13,
    REG_EEN   = 5'd14,
    REG_EDIS  = 5'd15,
    REG_CTRL  = 5'd16,
    REG_SAFE  = 5'd20
  } rtc_reg_e;

  localparam logic [31:0] CTRL_KEEP  = 32'h8F00_0001;
  localparam logic [31:0] CTRL_RESET = 32'h0100_0000;

  typedef struct packed {
    logic mapped;
    logic writable;
  } rtc_dec_t;

endpackage

// File: rtl/rtc_addr_dec.sv
module rtc_addr_dec
  import rtc_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output rtc_dec_t          dec
);

  always_comb begin
    dec = '0;
    case (addr)
      ADDR_W'(REG_TSET), ADDR_W'(REG_CALW), ADDR_W'(REG_ALRM),
      ADDR_W'(REG_ISTAT), ADDR_W'(REG_IEN), ADDR_W'(REG_IDIS),
      ADDR_W'(REG_ESTAT), ADDR_W'(REG_EEN), ADDR_W'(REG_EDIS),
      ADDR_W'(REG_CTRL), ADDR_W'(REG_SAFE): begin
        dec.mapped   = 1'b1;
        dec.writable = 1'b1;
      end
      ADDR_W'(REG_TSNAP), ADDR_W'(REG_CALR), ADDR_W'(REG_TNOW),
      ADDR_W'(REG_TICK), ADDR_W'(REG_IMASK), ADDR_W'(REG_EMASK): begin
        dec.mapped   = 1'b1;
        dec.writable = 1'b0;
      end
      default: dec = '0;
    endcase
  end

endmodule

// File: rtl/rtc_irq_group.sv
module rtc_irq_group #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         en_we,
  input  logic         dis_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);

  logic [W-1:0] stat_n, mask_n;

  // events are ORed in after the clear, so a same-cycle event survives
  always_comb begin
    stat_n = (status & ~(clr_we ? wbits : '0)) | evt;
    mask_n = (mask & ~(en_we ? wbits : '0)) | (dis_we ? wbits : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= stat_n;
      mask   <= mask_n;
      irq    <= |(stat_n & ~mask_n);
    end
  end

  assert_evt_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

  assert_en_clears_R4: assert property (@(posedge clk) disable iff (rst)
    en_we |=> ((mask & $past(wbits)) == '0));

  assert_dis_sets_R4: assert property (@(posedge clk) disable iff (rst)
    dis_we |=> ((mask & $past(wbits)) == $past(wbits)));

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_we && !dis_we) |=> $stable(mask));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (mask == '1) |-> !irq);

endmodule

// File: rtl/rtc_csr.sv
module rtc_csr
  import rtc_csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int TICK_W = 16,
  parameter int CAL_W  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic [DW-1:0]     time_now_i,
  input  logic [TICK_W-1:0] tick_now_i,
  input  logic [DW-1:0]     time_snap_i,
  input  logic [CAL_W-1:0]  calib_live_i,
  input  logic              ev_sec,
  input  logic              ev_alarm,
  output logic [DW-1:0]     set_time_o,
  output logic [CAL_W-1:0]  calib_o,
  output logic [DW-1:0]     alarm_o,
  output logic [DW-1:0]     ctrl_o,
  output logic              irq_rtc,
  output logic              irq_aerr
);

  localparam int RTC_SRC  = 2;
  localparam int AERR_SRC = 1;

  rtc_dec_t dec;
  logic wr_cyc, rd_cyc, bad_wr;
  logic [DW-1:0] set_time_q, alarm_q, ctrl_q, safety_q, rd_mux;
  logic [CAL_W-1:0] calib_q;
  logic [RTC_SRC-1:0]  rtc_stat, rtc_mask;
  logic [AERR_SRC-1:0] aerr_stat, aerr_mask;

  rtc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_cyc = bus_en & bus_wr;
  assign rd_cyc = bus_en & ~bus_wr;
  assign bad_wr = wr_cyc & ~dec.writable;

  function automatic logic wr_at(input rtc_reg_e r);
    return wr_cyc && (bus_addr == ADDR_W'(r));
  endfunction

  rtc_irq_group #(.W(RTC_SRC)) u_rtc_grp (
    .clk    (clk),
    .rst    (rst),
    .evt    ({ev_alarm, ev_sec}),
    .clr_we (wr_at(REG_ISTAT)),
    .en_we  (wr_at(REG_IEN)),
    .dis_we (wr_at(REG_IDIS)),
    .wbits  (bus_wdata[RTC_SRC-1:0]),
    .status (rtc_stat),
    .mask   (rtc_mask),
    .irq    (irq_rtc)
  );

  rtc_irq_group #(.W(AERR_SRC)) u_aerr_grp (
    .clk    (clk),
    .rst    (rst),
    .evt    (bad_wr),
    .clr_we (wr_at(REG_ESTAT)),
    .en_we  (wr_at(REG_EEN)),
    .dis_we (wr_at(REG_EDIS)),
    .wbits  (bus_wdata[AERR_SRC-1:0]),
    .status (aerr_stat),
    .mask   (aerr_mask),
    .irq    (irq_aerr)
  );

  // host-programmed storage
  always_ff @(posedge clk) begin
    if (rst) begin
      set_time_q <= '0;
      calib_q    <= '0;
      alarm_q    <= '0;
      ctrl_q     <= DW'(CTRL_RESET);
      safety_q   <= '0;
    end else begin
      if (wr_at(REG_TSET)) set_time_q <= bus_wdata;
      if (wr_at(REG_CALW)) calib_q    <= bus_wdata[CAL_W-1:0];
      if (wr_at(REG_ALRM)) alarm_q    <= bus_wdata;
      if (wr_at(REG_CTRL)) ctrl_q     <= bus_wdata & DW'(CTRL_KEEP);
      if (wr_at(REG_SAFE)) safety_q   <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(REG_TSET):  rd_mux = set_time_q;
      ADDR_W'(REG_TSNAP): rd_mux = time_snap_i;
      ADDR_W'(REG_CALW):  rd_mux = DW'(calib_q);
      ADDR_W'(REG_CALR):  rd_mux = DW'(calib_live_i);
      ADDR_W'(REG_TNOW):  rd_mux = time_now_i;
      ADDR_W'(REG_TICK):  rd_mux = DW'(tick_now_i);
      ADDR_W'(REG_ALRM):  rd_mux = alarm_q;
      ADDR_W'(REG_ISTAT): rd_mux = DW'(rtc_stat);
      ADDR_W'(REG_IMASK): rd_mux = DW'(rtc_mask);
      ADDR_W'(REG_ESTAT): rd_mux = DW'(aerr_stat);
      ADDR_W'(REG_EMASK): rd_mux = DW'(aerr_mask);
      ADDR_W'(REG_CTRL):  rd_mux = ctrl_q;
      ADDR_W'(REG_SAFE):  rd_mux = safety_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (rd_cyc) bus_rdata <= dec.mapped ? rd_mux : '0;
      bus_err <= bad_wr & ctrl_q[0];
    end
  end

  assign set_time_o = set_time_q;
  assign calib_o    = calib_q;
  assign alarm_o    = alarm_q;
  assign ctrl_o     = ctrl_q;

  assert_bad_wr_flags_R7: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> aerr_stat[0]);

  assert_err_gated_R8: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(ctrl_q[0]) && $past(bad_wr));

  assert_good_wr_no_err_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && dec.writable) |=> !bus_err);

  assert_unmapped_rd_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_cyc && !dec.mapped) |=> (bus_rdata == '0));

endmodule

// File: tb/rtc_csr_test.sv
`timescale 1ns/1ps
module rtc_csr_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err;
  logic [31:0] time_now_i = '0, time_snap_i = '0;
  logic [15:0] tick_now_i = '0;
  logic [20:0] calib_live_i = '0;
  logic        ev_sec = 1'b0, ev_alarm = 1'b0;
  logic [31:0] set_time_o, alarm_o, ctrl_o;
  logic [20:0] calib_o;
  logic        irq_rtc, irq_aerr;

  int total = 0, bad = 0;
  logic last_err;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_csr uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .time_now_i(time_now_i), .tick_now_i(tick_now_i), .time_snap_i(time_snap_i),
    .calib_live_i(calib_live_i), .ev_sec(ev_sec), .ev_alarm(ev_alarm),
    .set_time_o(set_time_o), .calib_o(calib_o), .alarm_o(alarm_o), .ctrl_o(ctrl_o),
    .irq_rtc(irq_rtc), .irq_aerr(irq_aerr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = off[6:2]; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    last_err = bus_err;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = off[6:2];
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] off, input logic [31:0] exp);
    logic [31:0] d;
    rd(off, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input bit alarm);
    @(negedge clk);
    if (alarm) ev_alarm = 1'b1; else ev_sec = 1'b1;
    @(negedge clk);
    ev_alarm = 1'b0; ev_sec = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 mask", 8'h24, 32'h3);
    rd_chk("R1 aerr mask", 8'h34, 32'h1);
    rd_chk("R1 control", 8'h40, 32'h0100_0000);
    rd_chk("R1 status", 8'h20, 32'h0);
    rd_chk("R1 aerr status", 8'h30, 32'h0);
    chk("R1 irqs", {30'd0, irq_rtc, irq_aerr}, 32'h0);
    chk("R1 bus_err", {31'd0, bus_err}, 32'h0);
  endtask

  task automatic t_live();
    time_now_i = 32'hA5A5_1234; tick_now_i = 16'hBEEF; time_snap_i = 32'h1357_9BDF;
    rd_chk("R11 time", 8'h10, 32'hA5A5_1234);
    rd_chk("R11 tick", 8'h14, 32'h0000_BEEF);
    rd_chk("R11 snap", 8'h04, 32'h1357_9BDF);
  endtask

  task automatic t_calib();
    calib_live_i = 21'h1A_BCDE;
    rd_chk("R9 calib live", 8'h0C, 32'h001A_BCDE);
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R9 calib trunc", 8'h08, 32'h001F_FFFF);
    wr(8'h08, 32'h0015_4321);
    rd_chk("R9 calib fields", 8'h08, 32'h0015_4321);
    chk("R9 calib_o", {11'd0, calib_o}, 32'h0015_4321);
  endtask

  task automatic t_plain();
    wr(8'h00, 32'hCAFE_0001);
    wr(8'h18, 32'h0000_0E10);
    wr(8'h50, 32'hDEAD_BEEF);
    rd_chk("R13 set-time", 8'h00, 32'hCAFE_0001);
    rd_chk("R13 alarm", 8'h18, 32'h0000_0E10);
    rd_chk("R13 safety", 8'h50, 32'hDEAD_BEEF);
    chk("R13 set_time_o", set_time_o, 32'hCAFE_0001);
    chk("R13 alarm_o", alarm_o, 32'h0000_0E10);
  endtask

  task automatic t_ctrl();
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R10 control keep", 8'h40, 32'h8F00_0001);
    chk("R10 ctrl_o", ctrl_o, 32'h8F00_0001);
    wr(8'h40, 32'h0);
    rd_chk("R10 control clear", 8'h40, 32'h0);
  endtask

  task automatic t_status();
    pulse(0);
    rd_chk("R2 seconds set", 8'h20, 32'h1);
    chk("R5 masked irq", {31'd0, irq_rtc}, 32'h0);
    pulse(1);
    rd_chk("R2 alarm set", 8'h20, 32'h3);
    wr(8'h20, 32'h0);
    rd_chk("R2 zero write", 8'h20, 32'h3);
    wr(8'h20, 32'h1);
    rd_chk("R2 clear seconds", 8'h20, 32'h2);
    wr(8'h20, 32'h2);
    rd_chk("R2 clear alarm", 8'h20, 32'h0);
  endtask

  task automatic t_mask();
    wr(8'h24, 32'h0);
    rd_chk("R4 mask read-only", 8'h24, 32'h3);
    rd_chk("R7 ro write flagged", 8'h30, 32'h1);
    wr(8'h30, 32'h1);
    wr(8'h28, 32'h1);
    rd_chk("R4 enable clears", 8'h24, 32'h2);
    rd_chk("R4 enable reads 0", 8'h28, 32'h0);
    pulse(0);
    chk("R5 irq on event", {31'd0, irq_rtc}, 32'h1);
    wr(8'h2C, 32'h1);
    chk("R5 irq off by disable", {31'd0, irq_rtc}, 32'h0);
    rd_chk("R4 disable sets", 8'h24, 32'h3);
    rd_chk("R4 disable reads 0", 8'h2C, 32'h0);
    wr(8'h28, 32'h3);
    chk("R5 irq on by enable", {31'd0, irq_rtc}, 32'h1);
    wr(8'h20, 32'h1);
    chk("R5 irq off by clear", {31'd0, irq_rtc}, 32'h0);
  endtask

  task automatic t_race();
    pulse(1);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'd8; bus_wdata = 32'h2; ev_alarm = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; ev_alarm = 1'b0;
    chk("R3 event beats clear irq", {31'd0, irq_rtc}, 32'h1);
    rd_chk("R3 event beats clear", 8'h20, 32'h2);
    wr(8'h20, 32'h2);
    rd_chk("R3 later clear", 8'h20, 32'h0);
  endtask

  task automatic t_aerr();
    wr(8'h10, 32'h1234_5678);
    rd_chk("R7 ro write flag", 8'h30, 32'h1);
    rd_chk("R7 time unchanged", 8'h10, 32'hA5A5_1234);
    chk("R6 irq masked", {31'd0, irq_aerr}, 32'h0);
    wr(8'h38, 32'h1);
    chk("R6 irq enabled", {31'd0, irq_aerr}, 32'h1);
    wr(8'h30, 32'h1);
    chk("R6 irq cleared", {31'd0, irq_aerr}, 32'h0);
    rd_chk("R6 status cleared", 8'h30, 32'h0);
    wr(8'h44, 32'hFFFF_FFFF);
    chk("R7 unmapped write irq", {31'd0, irq_aerr}, 32'h1);
    wr(8'h3C, 32'h1);
    chk("R6 disable drops irq", {31'd0, irq_aerr}, 32'h0);
    rd_chk("R6 mask set", 8'h34, 32'h1);
    wr(8'h30, 32'h1);
    rd_chk("R12 unmapped read", 8'h48, 32'h0);
    rd_chk("R12 read no flag", 8'h30, 32'h0);
  endtask

  task automatic t_slverr();
    wr(8'h14, 32'h0);
    chk("R8 no err when disabled", {31'd0, last_err}, 32'h0);
    wr(8'h40, 32'h1);
    chk("R8 legal write no err", {31'd0, last_err}, 32'h0);
    wr(8'h14, 32'h0);
    chk("R8 err raised", {31'd0, last_err}, 32'h1);
    @(negedge clk);
    chk("R8 err one cycle", {31'd0, bus_err}, 32'h0);
    wr(8'h18, 32'h5);
    chk("R8 accepted write no err", {31'd0, last_err}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_live();
    t_calib();
    t_plain();
    t_ctrl();
    t_status();
    t_mask();
    t_race();
    t_aerr();
    t_slverr();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule